// File: doc/BRIEF.md
# Colour Palette Loader

This block fills an on-chip colour lookup table from a stream of 32-bit palette words. Each accepted word is unpacked into one table entry. An entry holds a transparency flag and an 8-bit red, green and blue channel. How the colour fields are packed in the word depends on a 2-bit layout select and a grey-scale flag. The number of words to accept follows from the pixel depth code held in a 32-bit display configuration word.

A load begins with a one-cycle start request. The block takes the layout select and the grey-scale flag at that moment. It then accepts words over a valid/ready handshake and pulses `done` when the final entry has been written. The unconverted words are also kept. When the layout select later differs from the one in use, the block converts the whole table again from those kept words, and the source does not have to send the palette a second time. A pixel engine looks up colours through a synchronous read port.

Top module: `pal_loader`

## Requirements
- R1: After reset, `wordReady`, `done` and `lookupData` are all 0.
- R2: The depth code is `{cfgWord[29], cfgWord[26:24]}`. Codes 1, 2 and 3 make a load accept exactly 4, 16 and 256 words, written to entries 0 upward. `wordReady` rises only in the cycle after a start request.
- R3: A start request with any other depth code accepts no words and leaves every table entry unchanged. `done` pulses in the cycle after the request.
- R4: Entry layout is `{t, r[7:0], g[7:0], b[7:0]}`, with `t` at bit 24. Layout 0 gives r = {w[15:11],000}, g = {w[10:5],00}, b = {w[4:0],000} and t = 0.
- R5: Layout 1 gives the same colour as layout 0, with t = w[24].
- R6: Layout 2 gives r = {w[23:19],000}, g = {w[15:10],00}, b = {w[7:3],000} and t = w[24].
- R7: Layout 3 gives r = w[23:16], g = w[15:8], b = w[7:0] and t = w[24].
- R8: When the grey-scale flag is set, r, g and b all equal w[7:0] in every layout. The flag does not change how t is chosen.
- R9: `done` is high for the single cycle after the edge that accepts the final word. `wordReady` is low in that cycle.
- R10: While idle after a valid load, a change of the layout select converts entries 0 to N-1 again from the kept words. N is the entry count of the last valid load. The flag used is the grey-scale flag at the change. No words are taken. `done` pulses N+2 cycles after the change is first seen.
- R11: `lookupData` shows the entry at `lookupAddr` one clock edge after the address is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWord | input | 32 | Display configuration word holding the depth code |
| palFmt | input | 2 | Packed entry layout select |
| monoEn | input | 1 | Grey-scale override |
| loadStart | input | 1 | One-cycle request to start a palette load |
| wordValid | input | 1 | Palette word valid |
| wordData | input | 32 | Palette word |
| wordReady | output | 1 | Block accepts a word this cycle |
| done | output | 1 | Load, reject or reconversion finished |
| lookupAddr | input | 8 | Table read address |
| lookupData | output | 25 | Table entry read one cycle after the address |

## Verification
The assertions check the handshake framing on every cycle. `wordReady` rises only after a start request, it falls only together with `done`, and `done` never coincides with `wordReady`. They also check that a rejected depth code gives an immediate `done`, and that the control never asks the datapath to store a word and commit a reconverted entry in the same cycle. Only the bench scenarios can show the following:
- the bit-level unpacking of the four layouts and of the grey-scale override;
- that a rejected load leaves earlier entries untouched;
- the exact word counts per depth code;
- that a reconversion produces the new layout from the kept words, with its N+2 cycle latency.

// File: rtl/pal_pkg.sv
package pal_pkg;

  localparam int PAL_IDX_W   = 8;
  localparam int PAL_ENTRY_W = 25;
  localparam int PAL_RAW_W   = 25;
  localparam int PAL_DEPTH_W = 4;

  typedef enum logic [1:0] {
    FMT_RGB565   = 2'd0,
    FMT_RGB565_T = 2'd1,
    FMT_RGB666_T = 2'd2,
    FMT_RGB888_T = 2'd3
  } pal_fmt_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_REFR = 2'd2
  } pal_state_e;

  typedef struct packed {
    logic                 storeWord;
    logic [PAL_IDX_W-1:0] storeIdx;
    logic                 fetchRaw;
    logic [PAL_IDX_W-1:0] fetchIdx;
    logic                 commitRefresh;
    logic [PAL_IDX_W-1:0] refreshIdx;
    pal_fmt_e             fmt;
    logic                 mono;
  } pal_strobe_t;

  // Returns {supported, index of the last entry to load}
  function automatic logic [PAL_IDX_W:0] decodeDepth(input logic [PAL_DEPTH_W-1:0] code);
    logic [PAL_IDX_W:0] res;
    case (code)
      4'd1:    res = {1'b1, PAL_IDX_W'(3)};
      4'd2:    res = {1'b1, PAL_IDX_W'(15)};
      4'd3:    res = {1'b1, PAL_IDX_W'(255)};
      default: res = '0;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/pal_entry_conv.sv
module pal_entry_conv
  import pal_pkg::*;
#(
  parameter int RAW_W   = PAL_RAW_W,
  parameter int ENTRY_W = PAL_ENTRY_W
) (
  input  logic [RAW_W-1:0]   rawWord,
  input  pal_fmt_e           fmt,
  input  logic               mono,
  output logic [ENTRY_W-1:0] entry
);

  localparam int CH_W = 8;

  logic [CH_W-1:0] red, green, blue;
  logic            transp;

  always_comb begin
    transp = (fmt == FMT_RGB565) ? 1'b0 : rawWord[24];
    case (fmt)
      FMT_RGB666_T: begin
        red   = {rawWord[23:19], 3'b000};
        green = {rawWord[15:10], 2'b00};
        blue  = {rawWord[7:3],   3'b000};
      end
      FMT_RGB888_T: begin
        red   = rawWord[23:16];
        green = rawWord[15:8];
        blue  = rawWord[7:0];
      end
      default: begin
        red   = {rawWord[15:11], 3'b000};
        green = {rawWord[10:5],  2'b00};
        blue  = {rawWord[4:0],   3'b000};
      end
    endcase
    if (mono) begin
      red   = rawWord[7:0];
      green = rawWord[7:0];
      blue  = rawWord[7:0];
    end
    entry = {transp, red, green, blue};
  end

endmodule

// File: rtl/pal_loader_ctrl.sv
module pal_loader_ctrl
  import pal_pkg::*;
#(
  parameter int IDX_W = PAL_IDX_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             loadStart,
  input  logic             depthOk,
  input  logic [IDX_W-1:0] depthLast,
  input  logic [1:0]       palFmt,
  input  logic             monoEn,
  input  logic             wordValid,
  output logic             wordReady,
  output logic             done,
  output logic             busy,
  output pal_strobe_t      stb
);

  pal_state_e       state;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] lastIdx;
  logic             haveLoaded;
  logic             issueDone;
  logic             pipeValid;
  logic [IDX_W-1:0] pipeIdx;
  pal_fmt_e         fmtApplied;
  logic             monoApplied;
  logic             doneQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      idx         <= '0;
      lastIdx     <= '0;
      haveLoaded  <= 1'b0;
      issueDone   <= 1'b0;
      pipeValid   <= 1'b0;
      pipeIdx     <= '0;
      fmtApplied  <= FMT_RGB565;
      monoApplied <= 1'b0;
      doneQ       <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      case (state)
        ST_IDLE: begin
          pipeValid <= 1'b0;
          if (loadStart) begin
            if (depthOk) begin
              state       <= ST_LOAD;
              idx         <= '0;
              lastIdx     <= depthLast;
              fmtApplied  <= pal_fmt_e'(palFmt);
              monoApplied <= monoEn;
            end else begin
              doneQ <= 1'b1;
            end
          end else if (haveLoaded && (pal_fmt_e'(palFmt) != fmtApplied)) begin
            state       <= ST_REFR;
            idx         <= '0;
            issueDone   <= 1'b0;
            fmtApplied  <= pal_fmt_e'(palFmt);
            monoApplied <= monoEn;
          end
        end
        ST_LOAD: begin
          if (wordValid) begin
            idx <= idx + 1'b1;
            if (idx == lastIdx) begin
              state      <= ST_IDLE;
              doneQ      <= 1'b1;
              haveLoaded <= 1'b1;
            end
          end
        end
        ST_REFR: begin
          if (!issueDone) begin
            idx <= idx + 1'b1;
            if (idx == lastIdx) issueDone <= 1'b1;
          end
          pipeValid <= !issueDone;
          pipeIdx   <= idx;
          if (pipeValid && (pipeIdx == lastIdx)) begin
            state <= ST_IDLE;
            doneQ <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    stb.storeWord     = (state == ST_LOAD) && wordValid;
    stb.storeIdx      = idx;
    stb.fetchRaw      = (state == ST_REFR) && !issueDone;
    stb.fetchIdx      = idx;
    stb.commitRefresh = (state == ST_REFR) && pipeValid;
    stb.refreshIdx    = pipeIdx;
    stb.fmt           = fmtApplied;
    stb.mono          = monoApplied;
  end

  assign wordReady = (state == ST_LOAD);
  assign busy      = (state != ST_IDLE);
  assign done      = doneQ;

endmodule

// File: rtl/pal_loader_dp.sv
module pal_loader_dp
  import pal_pkg::*;
#(
  parameter int IDX_W   = PAL_IDX_W,
  parameter int RAW_W   = PAL_RAW_W,
  parameter int ENTRY_W = PAL_ENTRY_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  pal_strobe_t        stb,
  input  logic [RAW_W-1:0]   wordRaw,
  input  logic [IDX_W-1:0]   lookupAddr,
  output logic [ENTRY_W-1:0] lookupData
);

  localparam int ENTRIES = 1 << IDX_W;

  logic [RAW_W-1:0]   rawMem [ENTRIES];
  logic [ENTRY_W-1:0] palMem [ENTRIES];
  logic [RAW_W-1:0]   rawQ;
  logic [RAW_W-1:0]   convIn;
  logic [ENTRY_W-1:0] convOut;
  logic               wrEn;
  logic [IDX_W-1:0]   wrIdx;

  assign convIn = stb.storeWord ? wordRaw : rawQ;
  assign wrEn   = stb.storeWord || stb.commitRefresh;
  assign wrIdx  = stb.storeWord ? stb.storeIdx : stb.refreshIdx;

  pal_entry_conv #(.RAW_W(RAW_W), .ENTRY_W(ENTRY_W)) u_conv (
    .rawWord (convIn),
    .fmt     (stb.fmt),
    .mono    (stb.mono),
    .entry   (convOut)
  );

  always_ff @(posedge clk) begin
    if (stb.storeWord) rawMem[stb.storeIdx] <= wordRaw;
    if (stb.fetchRaw)  rawQ <= rawMem[stb.fetchIdx];
    if (wrEn)          palMem[wrIdx] <= convOut;
  end

  always_ff @(posedge clk) begin
    if (!rstN) lookupData <= '0;
    else       lookupData <= palMem[lookupAddr];
  end

endmodule

// File: rtl/pal_loader.sv
module pal_loader
  import pal_pkg::*;
#(
  parameter int IDX_W   = PAL_IDX_W,
  parameter int RAW_W   = PAL_RAW_W,
  parameter int ENTRY_W = PAL_ENTRY_W
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [31:0]        cfgWord,
  input  logic [1:0]         palFmt,
  input  logic               monoEn,
  input  logic               loadStart,
  input  logic               wordValid,
  input  logic [31:0]        wordData,
  output logic               wordReady,
  output logic               done,
  input  logic [IDX_W-1:0]   lookupAddr,
  output logic [ENTRY_W-1:0] lookupData
);

  logic [PAL_DEPTH_W-1:0] depthCode;
  logic                   depthOk;
  logic [IDX_W-1:0]       depthLast;
  logic                   busy;
  pal_strobe_t            stb;
  logic                   unusedBits;

  assign depthCode  = {cfgWord[29], cfgWord[26:24]};
  assign {depthOk, depthLast} = decodeDepth(depthCode);
  assign unusedBits = ^{cfgWord[31:30], cfgWord[28:27], cfgWord[23:0], wordData[31:RAW_W]};

  pal_loader_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadStart (loadStart),
    .depthOk   (depthOk),
    .depthLast (depthLast),
    .palFmt    (palFmt),
    .monoEn    (monoEn),
    .wordValid (wordValid),
    .wordReady (wordReady),
    .done      (done),
    .busy      (busy),
    .stb       (stb)
  );

  pal_loader_dp #(.IDX_W(IDX_W), .RAW_W(RAW_W), .ENTRY_W(ENTRY_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wordRaw    (wordData[RAW_W-1:0]),
    .lookupAddr (lookupAddr),
    .lookupData (lookupData)
  );

endmodule

// File: rtl/pal_loader_chk.sv
module pal_loader_chk
  import pal_pkg::*;
(
  input logic        clk,
  input logic        rstN,
  input logic        loadStart,
  input logic        wordReady,
  input logic        done,
  input logic        busy,
  input logic        depthOk,
  input pal_strobe_t stb
);

  // R2
  ready_after_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wordReady) |-> $past(loadStart));

  // R3
  reject_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && loadStart && !depthOk) |=> (done && !wordReady));

  // R9
  ready_fall_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(wordReady) |-> done);

  // R9
  done_not_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !wordReady);

  // R10
  single_writer_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.storeWord && stb.commitRefresh));

endmodule

bind pal_loader pal_loader_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .loadStart (loadStart),
  .wordReady (wordReady),
  .done      (done),
  .busy      (busy),
  .depthOk   (depthOk),
  .stb       (stb)
);

// File: tb/test_pal_loader.sv
`timescale 1ns/1ps
module test_pal_loader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] cfgWord = '0;
  logic [1:0]  palFmt = '0;
  logic        monoEn = 1'b0;
  logic        loadStart = 1'b0;
  logic        wordValid = 1'b0;
  logic [31:0] wordData = '0;
  logic        wordReady;
  logic        done;
  logic [7:0]  lookupAddr = '0;
  logic [24:0] lookupData;

  int          nChecks = 0;
  int          nFails  = 0;
  logic [24:0] rawM [256];
  logic [24:0] expM [256];
  int          refCount = 0;

  always #2 clk = ~clk;

  pal_loader i_pal_loader (
    .clk(clk), .rstN(rstN), .cfgWord(cfgWord), .palFmt(palFmt), .monoEn(monoEn),
    .loadStart(loadStart), .wordValid(wordValid), .wordData(wordData),
    .wordReady(wordReady), .done(done), .lookupAddr(lookupAddr), .lookupData(lookupData)
  );

  function automatic logic [24:0] refConv(input logic [24:0] w, input logic [1:0] f, input logic m);
    logic [7:0] r, g, b;
    logic t;
    t = (f == 2'd0) ? 1'b0 : w[24];
    case (f)
      2'd2:    begin r = {w[23:19], 3'b0}; g = {w[15:10], 2'b0}; b = {w[7:3], 3'b0}; end
      2'd3:    begin r = w[23:16]; g = w[15:8]; b = w[7:0]; end
      default: begin r = {w[15:11], 3'b0}; g = {w[10:5], 2'b0}; b = {w[4:0], 3'b0}; end
    endcase
    if (m) begin r = w[7:0]; g = w[7:0]; b = w[7:0]; end
    return {t, r, g, b};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic doLoad(input logic [31:0] cfg, input logic [1:0] fmt, input logic mono,
                        input int n, input bit gaps, input string tag);
    @(negedge clk);
    cfgWord = cfg; palFmt = fmt; monoEn = mono; loadStart = 1'b1;
    @(negedge clk);
    loadStart = 1'b0;
    chk(wordReady == 1'b1, "R2 ready after start", 32'(wordReady), 32'd1);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      w = $urandom();
      if (gaps) repeat ($urandom() % 3) @(negedge clk);
      wordData = w; wordValid = 1'b1;
      if (!wordReady) chk(1'b0, "R2 ready dropped early", 32'(i), 32'(n));
      rawM[i] = w[24:0];
      expM[i] = refConv(w[24:0], fmt, mono);
      @(negedge clk);
      wordValid = 1'b0;
    end
    chk(done == 1'b1 && wordReady == 1'b0, "R9 done after last word",
        {30'd0, done, wordReady}, 32'd2);
    @(negedge clk);
    chk(done == 1'b0 && wordReady == 1'b0, {tag, " R2 count exact"},
        {30'd0, done, wordReady}, 32'd0);
    refCount = n;
  endtask

  task automatic look(input logic [7:0] a, input string tag);
    @(negedge clk);
    lookupAddr = a;
    @(negedge clk);
    chk(lookupData == expM[a], tag, 32'(lookupData), 32'(expM[a]));
  endtask

  task automatic lookRange(input int n, input string tag);
    for (int i = 0; i < n; i++) look(8'(i), tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    nChecks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wordReady == 1'b0, "R1 wordReady", 32'(wordReady), 32'd0);
    chk(done == 1'b0, "R1 done", 32'(done), 32'd0);
    chk(lookupData == 25'd0, "R1 lookupData", 32'(lookupData), 32'd0);

    // R2 R4: 4-entry load, layout 0, other config bits random
    doLoad(($urandom() & 32'hD8FF_FFFF) | 32'h0100_0000, 2'd0, 1'b0, 4, 1'b0, "d1");
    lookRange(4, "R4 layout0");
    // R11 back-to-back addresses: one edge latency
    @(negedge clk); lookupAddr = 8'd2;
    @(negedge clk); chk(lookupData == expM[2], "R11 latency", 32'(lookupData), 32'(expM[2]));
    lookupAddr = 8'd0;
    @(negedge clk); chk(lookupData == expM[0], "R11 latency", 32'(lookupData), 32'(expM[0]));

    // R5: 16 entries, layout 1, gaps in valid
    doLoad(32'h0200_0000, 2'd1, 1'b0, 16, 1'b1, "d2");
    lookRange(16, "R5 layout1");

    // R6: 256 entries, layout 2
    doLoad(32'h0300_0000, 2'd2, 1'b0, 256, 1'b1, "d3");
    for (int i = 0; i < 24; i++) look(8'($urandom()), "R6 layout2");
    look(8'd255, "R6 layout2 last");

    // R3: unsupported codes (bit29 set with code bits 1 -> 9, and code 0), words offered
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cfgWord = (k == 0) ? 32'h2100_0000 : 32'h0000_0000;
      loadStart = 1'b1; wordValid = 1'b1; wordData = 32'h01FF_FFFF;
      @(negedge clk);
      loadStart = 1'b0;
      chk(done == 1'b1 && wordReady == 1'b0, "R3 reject done",
          {30'd0, done, wordReady}, 32'd2);
      repeat (3) @(negedge clk);
      chk(wordReady == 1'b0, "R3 no words taken", 32'(wordReady), 32'd0);
      wordValid = 1'b0;
    end
    look(8'd0, "R3 entry unchanged");
    look(8'd200, "R3 entry unchanged");

    // R7: layout 3
    doLoad(32'h0200_0000, 2'd3, 1'b0, 16, 1'b0, "d2");
    lookRange(16, "R7 layout3");
    look(8'd100, "R7 upper entries kept");

    // R8: grey-scale in layouts 3 and 0
    doLoad(32'h0200_0000, 2'd3, 1'b1, 16, 1'b0, "d2");
    lookRange(8, "R8 mono layout3");
    doLoad(32'h0100_0000, 2'd0, 1'b1, 4, 1'b1, "d1");
    lookRange(4, "R8 mono layout0");

    // R10: reconvert 16-entry table on layout change
    doLoad(32'h0200_0000, 2'd0, 1'b0, 16, 1'b0, "d2");
    begin
      int cyc;
      @(negedge clk);
      palFmt = 2'd3; monoEn = 1'b0;
      cyc = 0;
      do begin
        @(negedge clk);
        cyc++;
      end while (!done && cyc < 2000);
      chk(cyc == 18, "R10 reconvert latency", 32'(cyc), 32'd18);
      chk(wordReady == 1'b0, "R10 no words taken", 32'(wordReady), 32'd0);
      for (int i = 0; i < 16; i++) expM[i] = refConv(rawM[i], 2'd3, 1'b0);
    end
    lookRange(16, "R10 reconverted");
    look(8'd77, "R10 untouched entry");

    // R10: second change, to layout 2 with grey-scale
    begin
      int cyc;
      @(negedge clk);
      palFmt = 2'd2; monoEn = 1'b1;
      cyc = 0;
      do begin
        @(negedge clk);
        cyc++;
      end while (!done && cyc < 2000);
      chk(cyc == refCount + 2, "R10 reconvert latency", 32'(cyc), 32'(refCount + 2));
      for (int i = 0; i < 16; i++) expM[i] = refConv(rawM[i], 2'd2, 1'b1);
    end
    lookRange(16, "R10 reconverted mono");

    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule